// File: doc/BRIEF.md
# Snooping L2 Cache Response Controller

This block is the decision logic of a lookaside second-level cache that sits beside a processor bus and watches every transaction on it. Each cycle in which a transaction is presented, it looks up a small direct-mapped tag array (valid bit, dirty bit and tag per set). It combines that result with the transaction kind, the burst flag, the cache-inhibit flag and the write-through flag, and picks one response. The possible responses are: claim with address and transfer acknowledge, line fill, cache update, invalidate, write-back with retry and bus request, cancel with retry, and service from the cast-out buffer. The data store is a plain array holding one whole line (four beats) per set.

Dirty victims and dirty lines that must be written back are moved into a one-entry cast-out buffer. The buffer drains to memory over a valid/ready write port. An address-retry input arriving in the cycle after a line fill undoes that fill: the old tag entry comes back, and any cast-out entry the fill created is dropped. A one-deep snoop history changes how the next processor burst write is handled. Snoop transactions are presented on the same inputs with their own kind codes.

The block assumes one transaction at a time, with at least one idle cycle between transactions. The response is registered and appears in the cycle after the transaction. Kind codes on `txn_kind`: 0 read, 1 write, 2 flush, 3 clean, 4 kill, 5 snoop read, 6 snoop write, 7 idle. Action codes on `resp_act`: 0 none, 1 claim, 2 fill, 3 update, 4 invalidate, 5 write-back, 6 cancel, 7 cast-out service. A line address is split into a low set index of log2(SETS) bits and a high tag.

Top module: `l2_snoop_ctrl`

## Requirements
- R1: A cacheable read or write that hits, with no special rule applying, gives action 1 with claim, aack and ta. A read returns the stored line on `resp_rdata`, and a write stores `txn_wdata` and marks the line dirty.
- R2: A cacheable burst read that misses both the cache and the cast-out buffer gives action 2 with aack and ta but no claim. `resp_rdata` equals `fill_data`, and the line becomes valid and clean. A single-beat read miss gives action 0.
- R3: A fill or write-back that displaces a dirty line with the cast-out buffer empty moves that line to the buffer. The buffer then offers it on `wb_addr`/`wb_data` with `wb_valid` and clears after a cycle with `wb_ready` high.
- R4: A fill whose victim is dirty while the cast-out buffer is full gives action 6 (retry, no bus request) and changes nothing. The exception is a burst write whose address equals the buffered line: that fill proceeds and the victim replaces the buffered line. A write-back that needs a full buffer also gives action 6.
- R5: A burst read that misses the cache but matches the cast-out buffer address gives action 7 with claim, aack, ta and the buffered data, and no fill takes place.
- R6: `artry_in` high in the cycle after a fill restores the victim's valid bit, dirty bit, tag and data. It also invalidates a cast-out entry that the fill loaded.
- R7: `artry_in` high in the response cycle of a read hit withholds `resp_ta`.
- R8: A cache-inhibited read or write that hits a clean line invalidates it (action 4). On a dirty hit it gives action 5 (retry and bus request), writes the line back and invalidates it.
- R9: A write-through write that hits gives action 3, stores the data and leaves the line clean. A write-through miss gives action 0.
- R10: After a snoop write that hit, a burst write that hits invalidates the line (action 4). After any snoop write, a burst write that misses allocates nothing (action 0).
- R11: After a snoop read that hit, a burst write that hits gives action 3 and leaves the line clean. The snoop history is forgotten after the next processor transaction.
- R12: Flush invalidates a clean hit and writes back then invalidates a dirty hit. Clean does nothing on a clean hit and writes back a dirty hit while keeping it valid and clean. Kill invalidates any hit.
- R13: After reset every set is invalid, all response outputs are low and `wb_valid` is low.
- R14: While `wb_valid` is high and `wb_ready` low with no transaction, `wb_valid` and `wb_addr` hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_valid | input | 1 | A transaction is presented this cycle |
| txn_kind | input | 3 | Transaction kind code |
| txn_addr | input | ADDR_W | Line address |
| txn_burst | input | 1 | Burst (whole-line) transfer |
| txn_inhibit | input | 1 | Cache-inhibited access |
| txn_wthru | input | 1 | Write-through access |
| txn_wdata | input | BEATS*BEAT_W | Write line data |
| fill_data | input | BEATS*BEAT_W | Line returned by memory for a fill |
| artry_in | input | 1 | Address retry from the bus |
| resp_claim | output | 1 | Cache claims the transfer |
| resp_aack | output | 1 | Address acknowledge |
| resp_ta | output | 1 | Transfer acknowledge |
| resp_retry | output | 1 | Retry driven to the bus |
| resp_busreq | output | 1 | Bus request for a write-back |
| resp_act | output | 3 | Action code chosen |
| resp_rdata | output | BEATS*BEAT_W | Read line data |
| wb_valid | output | 1 | Cast-out line offered to memory |
| wb_ready | input | 1 | Memory accepts the cast-out line |
| wb_addr | output | ADDR_W | Cast-out line address |
| wb_data | output | BEATS*BEAT_W | Cast-out line data |

## Verification
Every response output is registered once, so it is due in the cycle after the transaction's edge. The bench drives at the falling edge, lets one rising edge pass and samples at the next falling edge. Retry is driven at that same falling edge before sampling, because `resp_ta` reacts to it combinationally. Any rollback lands on the following rising edge. The cast-out port is therefore checked one falling edge later, after that edge. Drains are done as a separate cycle with `wb_ready` raised, so the bench's model of the buffer never races the design's.

// File: rtl/l2sc_pkg.sv
// Package: shared codes for the snooping L2 response controller.
// Assumes nothing beyond 3-bit kind and action fields.
package l2sc_pkg;
    typedef enum logic [2:0] {
        K_READ = 3'd0, K_WRITE = 3'd1, K_FLUSH = 3'd2, K_CLEAN = 3'd3,
        K_KILL = 3'd4, K_SNRD = 3'd5, K_SNWR = 3'd6, K_IDLE = 3'd7
    } kind_e;

    typedef enum logic [2:0] {
        A_NONE = 3'd0, A_CLAIM = 3'd1, A_FILL = 3'd2, A_UPDATE = 3'd3,
        A_INVAL = 3'd4, A_WBACK = 3'd5, A_CANCEL = 3'd6, A_COBSRV = 3'd7
    } act_e;

    // Effect on the addressed tag/data entry.
    typedef enum logic [2:0] {
        T_KEEP, T_WRD, T_WRC, T_CLRD, T_INVAL, T_FILL
    } tagop_e;
endpackage

// File: rtl/l2sc_tags.sv
// Direct-mapped tag and line store. One combinational lookup port and one
// synchronous write port. Assumes at most one write per cycle; valid and
// dirty bits are cleared by reset, tag and data are not.
module l2sc_tags #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 4,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_data,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_data
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   v_q;
    logic [SETS-1:0]   d_q;
    logic [TAG_W-1:0]  t_q   [SETS];
    logic [LINE_W-1:0] dat_q [SETS];

    // State bits: reset to invalid/clean, written on we.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            d_q <= '0;
        end else if (we) begin
            v_q[wr_idx] <= wr_valid;
            d_q[wr_idx] <= wr_dirty;
        end
    end

    // Tag and line payload: plain storage, no reset.
    always_ff @(posedge clk) begin
        if (we) begin
            t_q[wr_idx]   <= wr_tag;
            dat_q[wr_idx] <= wr_data;
        end
    end

    // Lookup port.
    always_comb begin
        rd_valid = v_q[rd_idx];
        rd_dirty = d_q[rd_idx];
        rd_tag   = t_q[rd_idx];
        rd_data  = dat_q[rd_idx];
    end
endmodule

// File: rtl/l2sc_cob.sv
// One-entry cast-out buffer draining over a valid/ready write port.
// Assumes load and kill are never raised together. Drain can be blocked
// while an entry it holds may still be undone by a retry.
module l2sc_cob #(
    parameter int ADDR_W = 8,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [LINE_W-1:0] ld_data,
    input  logic              kill,
    input  logic              block,
    output logic              cob_valid,
    output logic [ADDR_W-1:0] cob_addr,
    output logic [LINE_W-1:0] cob_data,
    output logic              wb_valid,
    input  logic              wb_ready
);
    // Entry state: kill, then load, then drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cob_valid <= 1'b0;
        end else if (kill) begin
            cob_valid <= 1'b0;
        end else if (load) begin
            cob_valid <= 1'b1;
        end else if (wb_valid && wb_ready) begin
            cob_valid <= 1'b0;
        end
    end

    // Payload capture on load.
    always_ff @(posedge clk) begin
        if (load) begin
            cob_addr <= ld_addr;
            cob_data <= ld_data;
        end
    end

    // Offer to memory unless a pending retry could still cancel the entry.
    assign wb_valid = cob_valid && !block;

    // R3
    cob_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load && !kill |=> cob_valid && cob_addr == $past(ld_addr));
    // R14
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready && !load && !kill |=> wb_valid && $stable(cob_addr));
endmodule

// File: rtl/l2sc_decide.sv
// Response decision: pure combinational map from transaction attributes,
// lookup result, cast-out buffer state and snoop history to an action and
// the side effects on the tag entry and the cast-out buffer.
module l2sc_decide
    import l2sc_pkg::*;
(
    input  kind_e  kind,
    input  logic   burst,
    input  logic   inh,
    input  logic   wt,
    input  logic   hit,
    input  logic   ent_valid,
    input  logic   ent_dirty,
    input  logic   cob_v,
    input  logic   cob_hit,
    input  logic   snp_v,
    input  logic   snp_wr,
    input  logic   snp_hit,
    output act_e   act,
    output tagop_e tagop,
    output logic   cob_load,
    output logic   cob_kill,
    output logic   fill_dirty
);
    logic hd, vic_dirty, is_wr;

    // Select one action per transaction.
    always_comb begin
        act = A_NONE; tagop = T_KEEP;
        cob_load = 1'b0; cob_kill = 1'b0; fill_dirty = 1'b0;
        hd        = hit && ent_dirty;
        vic_dirty = !hit && ent_valid && ent_dirty;
        is_wr     = (kind == K_WRITE);
        case (kind)
            K_READ, K_WRITE: begin
                if (inh) begin
                    if (hit && !hd) begin act = A_INVAL; tagop = T_INVAL; end
                    else if (hd) begin
                        if (cob_v) act = A_CANCEL;
                        else begin act = A_WBACK; tagop = T_INVAL; cob_load = 1'b1; end
                    end
                end else if (is_wr && wt) begin
                    if (hit) begin act = A_UPDATE; tagop = T_WRC; end
                end else if (is_wr && burst && snp_v && snp_wr && snp_hit) begin
                    if (hit) begin act = A_INVAL; tagop = T_INVAL; end
                end else if (is_wr && burst && snp_v && snp_wr && !hit) begin
                    act = A_NONE;
                end else if (is_wr && burst && snp_v && !snp_wr && snp_hit && hit) begin
                    act = A_UPDATE; tagop = T_WRC;
                end else if (hit) begin
                    act = A_CLAIM; tagop = is_wr ? T_WRD : T_KEEP;
                end else if (burst && !is_wr && cob_hit) begin
                    act = A_COBSRV;
                end else if (burst) begin
                    if (vic_dirty && cob_v && !(is_wr && cob_hit)) act = A_CANCEL;
                    else begin
                        act = A_FILL; tagop = T_FILL; fill_dirty = is_wr;
                        cob_load = vic_dirty;
                        cob_kill = is_wr && cob_hit && !vic_dirty;
                    end
                end
            end
            K_FLUSH, K_CLEAN: begin
                if (hd) begin
                    if (cob_v) act = A_CANCEL;
                    else begin
                        act = A_WBACK; cob_load = 1'b1;
                        tagop = (kind == K_FLUSH) ? T_INVAL : T_CLRD;
                    end
                end else if (hit && kind == K_FLUSH) begin
                    act = A_INVAL; tagop = T_INVAL;
                end
            end
            K_KILL: if (hit) begin act = A_INVAL; tagop = T_INVAL; end
            default: act = A_NONE;
        endcase
    end
endmodule

// File: rtl/l2_snoop_ctrl.sv
// Top of the snooping L2 response controller. Looks up the tag store,
// asks the decision block for an action, applies the entry update, keeps
// the snoop history and the one-cycle fill rollback window, and registers
// the bus response. Assumes an idle cycle between transactions.
module l2_snoop_ctrl
    import l2sc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SETS   = 16,
    parameter int BEATS  = 4,
    parameter int BEAT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    txn_valid,
    input  logic [2:0]              txn_kind,
    input  logic [ADDR_W-1:0]       txn_addr,
    input  logic                    txn_burst,
    input  logic                    txn_inhibit,
    input  logic                    txn_wthru,
    input  logic [BEATS*BEAT_W-1:0] txn_wdata,
    input  logic [BEATS*BEAT_W-1:0] fill_data,
    input  logic                    artry_in,
    output logic                    resp_claim,
    output logic                    resp_aack,
    output logic                    resp_ta,
    output logic                    resp_retry,
    output logic                    resp_busreq,
    output logic [2:0]              resp_act,
    output logic [BEATS*BEAT_W-1:0] resp_rdata,
    output logic                    wb_valid,
    input  logic                    wb_ready,
    output logic [ADDR_W-1:0]       wb_addr,
    output logic [BEATS*BEAT_W-1:0] wb_data
);
    localparam int LINE_W = BEATS * BEAT_W;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W;

    kind_e             kind;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic              rd_valid, rd_dirty, hit, cob_hit;
    logic [TAG_W-1:0]  rd_tag;
    logic [LINE_W-1:0] rd_data;
    logic              cob_valid;
    logic [ADDR_W-1:0] cob_addr;
    logic [LINE_W-1:0] cob_data;
    act_e              act;
    tagop_e            tagop;
    logic              d_load, d_kill, fill_dirty;
    logic              snp_v, snp_wr, snp_hit;
    logic              pend_q, loaded_q, rd_claim_q, ta_q;
    logic [IDX_W-1:0]  sv_idx;
    logic              sv_valid, sv_dirty;
    logic [TAG_W-1:0]  sv_tag;
    logic [LINE_W-1:0] sv_data;
    logic              rollback, we, wr_valid, wr_dirty;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [LINE_W-1:0] wr_data, rdata_d;

    assign kind     = kind_e'(txn_kind);
    assign idx      = txn_addr[IDX_W-1:0];
    assign tag      = txn_addr[ADDR_W-1:IDX_W];
    assign hit      = rd_valid && (rd_tag == tag);
    assign cob_hit  = cob_valid && (cob_addr == txn_addr);
    assign rollback = pend_q && artry_in;

    l2sc_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .rd_idx(idx), .rd_valid(rd_valid),
        .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_data(rd_data),
        .we(we), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_dirty(wr_dirty),
        .wr_tag(wr_tag), .wr_data(wr_data)
    );

    l2sc_decide u_decide (
        .kind(kind), .burst(txn_burst), .inh(txn_inhibit), .wt(txn_wthru),
        .hit(hit), .ent_valid(rd_valid), .ent_dirty(rd_dirty),
        .cob_v(cob_valid), .cob_hit(cob_hit), .snp_v(snp_v), .snp_wr(snp_wr),
        .snp_hit(snp_hit), .act(act), .tagop(tagop), .cob_load(d_load),
        .cob_kill(d_kill), .fill_dirty(fill_dirty)
    );

    l2sc_cob #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_cob (
        .clk(clk), .rst_n(rst_n), .load(txn_valid && d_load),
        .ld_addr({rd_tag, idx}), .ld_data(rd_data),
        .kill((txn_valid && d_kill) || (rollback && loaded_q)),
        .block(pend_q && loaded_q), .cob_valid(cob_valid),
        .cob_addr(cob_addr), .cob_data(cob_data), .wb_valid(wb_valid),
        .wb_ready(wb_ready)
    );
    assign wb_addr = cob_addr;
    assign wb_data = cob_data;

    // Entry write: rollback restores the saved victim, else apply tag op.
    always_comb begin
        we = 1'b0; wr_idx = idx; wr_valid = rd_valid; wr_dirty = rd_dirty;
        wr_tag = rd_tag; wr_data = rd_data;
        if (rollback) begin
            we = 1'b1; wr_idx = sv_idx; wr_valid = sv_valid;
            wr_dirty = sv_dirty; wr_tag = sv_tag; wr_data = sv_data;
        end else if (txn_valid) begin
            we = (tagop != T_KEEP);
            case (tagop)
                T_WRD:   begin wr_valid = 1'b1; wr_dirty = 1'b1; wr_data = txn_wdata; end
                T_WRC:   begin wr_valid = 1'b1; wr_dirty = 1'b0; wr_data = txn_wdata; end
                T_CLRD:  wr_dirty = 1'b0;
                T_INVAL: begin wr_valid = 1'b0; wr_dirty = 1'b0; end
                T_FILL:  begin
                    wr_valid = 1'b1; wr_dirty = fill_dirty; wr_tag = tag;
                    wr_data  = fill_dirty ? txn_wdata : fill_data;
                end
                default: we = 1'b0;
            endcase
        end
    end

    // Read data source for the response.
    always_comb begin
        rdata_d = '0;
        if (kind == K_READ) begin
            if (act == A_CLAIM)       rdata_d = rd_data;
            else if (act == A_COBSRV) rdata_d = cob_data;
            else if (act == A_FILL)   rdata_d = fill_data;
        end
    end

    // Snoop history: set by a snoop, forgotten after a processor transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snp_v <= 1'b0; snp_wr <= 1'b0; snp_hit <= 1'b0;
        end else if (txn_valid && (kind == K_SNRD || kind == K_SNWR)) begin
            snp_v <= 1'b1; snp_wr <= (kind == K_SNWR); snp_hit <= hit;
        end else if (txn_valid && kind != K_IDLE) begin
            snp_v <= 1'b0;
        end
    end

    // Rollback window: one cycle after a fill, with the victim saved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0; loaded_q <= 1'b0;
        end else begin
            pend_q   <= txn_valid && (act == A_FILL);
            loaded_q <= txn_valid && (act == A_FILL) && d_load;
        end
    end

    // Victim snapshot captured with each transaction.
    always_ff @(posedge clk) begin
        if (txn_valid) begin
            sv_idx <= idx; sv_valid <= rd_valid; sv_dirty <= rd_dirty;
            sv_tag <= rd_tag; sv_data <= rd_data;
        end
    end

    // Registered bus response, one cycle after the transaction.
    always_ff @(posedge clk) begin
        if (!rst_n || !txn_valid) begin
            resp_claim <= 1'b0; resp_aack <= 1'b0; ta_q <= 1'b0;
            resp_retry <= 1'b0; resp_busreq <= 1'b0; resp_act <= A_NONE;
            resp_rdata <= '0; rd_claim_q <= 1'b0;
        end else begin
            resp_claim  <= act inside {A_CLAIM, A_UPDATE, A_COBSRV};
            resp_aack   <= act inside {A_CLAIM, A_UPDATE, A_COBSRV, A_FILL};
            ta_q        <= act inside {A_CLAIM, A_UPDATE, A_COBSRV, A_FILL};
            resp_retry  <= act inside {A_WBACK, A_CANCEL};
            resp_busreq <= (act == A_WBACK);
            resp_act    <= act;
            resp_rdata  <= rdata_d;
            rd_claim_q  <= (act == A_CLAIM) && (kind == K_READ);
        end
    end

    // Transfer acknowledge, withdrawn by a retry on a read hit.
    assign resp_ta = ta_q && !(rd_claim_q && artry_in);

    // R1
    ta_aack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ta |-> resp_aack);
    // R4
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_act == A_CANCEL |-> resp_retry && !resp_busreq && !resp_aack);
    // R2
    fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_act == A_FILL |-> resp_aack && !resp_claim && !resp_retry);
    // R6
    rollback_cob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && artry_in && loaded_q |=> !cob_valid);
    // R8
    busreq_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_busreq |-> resp_retry && !resp_claim);
    // R11
    snoop_forget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_kind <= 3'd4 |=> !snp_v);
endmodule

// File: tb/l2_snoop_ctrl_tb.sv
module l2_snoop_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETS = 16;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        txn_valid = 1'b0, txn_burst = 1'b0, txn_inhibit = 1'b0, txn_wthru = 1'b0;
    logic [2:0]  txn_kind = 3'd7;
    logic [7:0]  txn_addr = '0;
    logic [63:0] txn_wdata = '0, fill_data = '0;
    logic        artry_in = 1'b0, wb_ready = 1'b0;
    logic        resp_claim, resp_aack, resp_ta, resp_retry, resp_busreq, wb_valid;
    logic [2:0]  resp_act;
    logic [63:0] resp_rdata, wb_data;
    logic [7:0]  wb_addr;

    l2_snoop_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_kind(txn_kind),
        .txn_addr(txn_addr), .txn_burst(txn_burst), .txn_inhibit(txn_inhibit),
        .txn_wthru(txn_wthru), .txn_wdata(txn_wdata), .fill_data(fill_data),
        .artry_in(artry_in), .resp_claim(resp_claim), .resp_aack(resp_aack),
        .resp_ta(resp_ta), .resp_retry(resp_retry), .resp_busreq(resp_busreq),
        .resp_act(resp_act), .resp_rdata(resp_rdata), .wb_valid(wb_valid),
        .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0;
    bit finished = 0;

    // Reference state, built from the requirements.
    bit          m_v [SETS];
    bit          m_d [SETS];
    logic [3:0]  m_t [SETS];
    logic [63:0] m_dat [SETS];
    bit          m_cv = 0;
    logic [7:0]  m_ca;
    logic [63:0] m_cd;
    bit          s_v = 0, s_w = 0, s_h = 0;

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    function automatic string tag_of(input int a, input int k);
        case (a)
            1: return "R1";  2: return "R2";  3: return "R9";  4: return (k >= 2) ? "R12" : "R8";
            5: return "R8";  6: return "R4";  7: return "R5";  default: return "R2";
        endcase
    endfunction

    // One transaction: drive, check response, apply model, then drain phase.
    task automatic run_txn(input int k, input logic [7:0] a, input bit b, input bit inh, input bit wt,
                           input logic [63:0] wd, input logic [63:0] fd, input bit ar, input bit dr,
                           input int want, input string req);
        int idx = int'(a[3:0]);
        logic [3:0] tg = a[7:4];
        bit hit = m_v[idx] && m_t[idx] == tg;
        bit hd = hit && m_d[idx];
        bit vd = !hit && m_v[idx] && m_d[idx];
        bit ch = m_cv && m_ca == a;
        bit wr = (k == 1);
        bit ld = 0;
        int act = 0;
        bit ov = m_v[idx], od = m_d[idx];
        logic [3:0] ot = m_t[idx];
        logic [63:0] odat = m_dat[idx];
        logic [63:0] erd = '0;
        bit cl, ak, ta, rt, br;
        string rq;
        if (k <= 1) begin
            if (inh) begin
                if (hit && !hd) act = 4; else if (hd) act = m_cv ? 6 : 5;
            end else if (wr && wt) begin
                if (hit) act = 3;
            end else if (wr && b && s_v && s_w && s_h) begin
                if (hit) act = 4;
            end else if (wr && b && s_v && s_w && !hit) act = 0;
            else if (wr && b && s_v && !s_w && s_h && hit) act = 3;
            else if (hit) act = 1;
            else if (b && !wr && ch) act = 7;
            else if (b) act = (vd && m_cv && !(wr && ch)) ? 6 : 2;
        end else if (k == 2 || k == 3) begin
            if (hd) act = m_cv ? 6 : 5; else if (hit && k == 2) act = 4;
        end else if (k == 4) begin
            if (hit) act = 4;
        end
        rq = (req == "") ? tag_of(act, k) : req;
        if (want >= 0) chk(rq, "model action", act, want);
        if (k == 0) erd = (act == 1) ? m_dat[idx] : (act == 7) ? m_cd : (act == 2) ? fd : '0;
        cl = act inside {1, 3, 7};
        ak = cl || act == 2;
        ta = ak && !(ar && act == 1 && k == 0);
        rt = act inside {5, 6};
        br = act == 5;
        @(negedge clk);
        txn_valid = 1; txn_kind = 3'(k); txn_addr = a; txn_burst = b;
        txn_inhibit = inh; txn_wthru = wt; txn_wdata = wd; fill_data = fd;
        @(posedge clk);
        @(negedge clk);
        txn_valid = 0; artry_in = ar;
        #1;
        chk(rq, "act", resp_act, act);
        chk(rq, "claim", resp_claim, cl);
        chk(rq, "aack", resp_aack, ak);
        chk(ar && act == 1 ? "R7" : rq, "ta", resp_ta, ta);
        chk(rq, "retry", resp_retry, rt);
        chk(rq, "busreq", resp_busreq, br);
        if (k == 0) chk(rq, "rdata", resp_rdata, erd);
        // apply model
        case (act)
            1: if (wr) begin m_d[idx] = 1; m_dat[idx] = wd; end
            2: begin
                if (vd) begin m_cv = 1; m_ca = {m_t[idx], a[3:0]}; m_cd = m_dat[idx]; ld = 1; end
                else if (wr && ch) m_cv = 0;
                m_v[idx] = 1; m_d[idx] = wr; m_t[idx] = tg; m_dat[idx] = wr ? wd : fd;
            end
            3: begin m_d[idx] = 0; m_dat[idx] = wd; end
            4: begin m_v[idx] = 0; m_d[idx] = 0; end
            5: begin
                m_cv = 1; m_ca = a; m_cd = m_dat[idx];
                if (k == 3) m_d[idx] = 0; else begin m_v[idx] = 0; m_d[idx] = 0; end
            end
            default: ;
        endcase
        if (k == 5 || k == 6) begin s_v = 1; s_w = (k == 6); s_h = hit; end
        else if (k <= 4) s_v = 0;
        if (ar && act == 2) begin
            m_v[idx] = ov; m_d[idx] = od; m_t[idx] = ot; m_dat[idx] = odat;
            if (ld) m_cv = 0;
        end
        @(posedge clk);
        @(negedge clk);
        artry_in = 0;
        chk((ar && act == 2) ? "R6" : "R3", "wb_valid", wb_valid, m_cv);
        if (m_cv) begin
            chk("R3", "wb_addr", wb_addr, m_ca);
            chk("R3", "wb_data", wb_data, m_cd);
        end
        if (dr && m_cv) begin
            wb_ready = 1;
            @(posedge clk);
            @(negedge clk);
            wb_ready = 0;
            m_cv = 0;
            chk("R3", "wb_valid after drain", wb_valid, 0);
        end else if (m_cv) begin
            @(posedge clk);
            @(negedge clk);
            chk("R14", "wb_valid held", wb_valid, 1);
            chk("R14", "wb_addr held", wb_addr, m_ca);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < SETS; i++) begin m_v[i] = 0; m_d[i] = 0; m_t[i] = '0; m_dat[i] = '0; end
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        // R13: reset state
        chk("R13", "act", resp_act, 0);
        chk("R13", "aack", resp_aack, 0);
        chk("R13", "ta", resp_ta, 0);
        chk("R13", "retry", resp_retry, 0);
        chk("R13", "wb_valid", wb_valid, 0);
        for (int i = 0; i < 4; i++) run_txn(0, 8'(i), 0, 0, 0, '0, '0, 0, 0, 0, "R13");

        // R2 fill and single-beat miss
        run_txn(0, 8'h01, 1, 0, 0, '0, 64'hA1, 0, 0, 2, "R2");
        run_txn(0, 8'h09, 0, 0, 0, '0, 64'hEE, 0, 0, 0, "R2");
        // R1 read hit, write hit
        run_txn(0, 8'h01, 1, 0, 0, '0, '0, 0, 0, 1, "R1");
        run_txn(1, 8'h01, 1, 0, 0, 64'hB1, '0, 0, 0, 1, "R1");
        // R3 dirty victim to the buffer (kept)
        run_txn(0, 8'h11, 1, 0, 0, '0, 64'hC1, 0, 0, 2, "R3");
        run_txn(1, 8'h11, 1, 0, 0, 64'hD1, '0, 0, 0, 1, "R1");
        // R4 dirty victim, buffer full
        run_txn(0, 8'h21, 1, 0, 0, '0, 64'hE1, 0, 0, 6, "R4");
        // R5 served from the buffer
        run_txn(0, 8'h01, 1, 0, 0, '0, 64'hF1, 0, 0, 7, "R5");
        // R4 exception: write to the buffered line proceeds
        run_txn(1, 8'h01, 1, 0, 0, 64'hB2, '0, 0, 1, 2, "R4");
        // R6 rollback of a fill with dirty victim
        run_txn(0, 8'h21, 1, 0, 0, '0, 64'hE2, 1, 0, 2, "R6");
        run_txn(0, 8'h01, 1, 0, 0, '0, '0, 0, 0, 1, "R6");
        // R7 retry on a read hit
        run_txn(0, 8'h01, 1, 0, 0, '0, '0, 1, 0, 1, "R7");
        // R8 inhibited accesses
        run_txn(0, 8'h01, 1, 1, 0, '0, '0, 0, 1, 5, "R8");
        run_txn(0, 8'h02, 1, 0, 0, '0, 64'hA2, 0, 0, 2, "R2");
        run_txn(1, 8'h02, 1, 1, 0, 64'h1, '0, 0, 0, 4, "R8");
        run_txn(0, 8'h02, 0, 0, 0, '0, '0, 0, 0, 0, "R8");
        // R9 write-through
        run_txn(0, 8'h03, 1, 0, 0, '0, 64'hA3, 0, 0, 2, "R2");
        run_txn(1, 8'h03, 1, 0, 0, 64'hB3, '0, 0, 0, 1, "R1");
        run_txn(1, 8'h03, 1, 0, 1, 64'hC3, '0, 0, 0, 3, "R9");
        run_txn(2, 8'h03, 0, 0, 0, '0, '0, 0, 0, 4, "R9");
        run_txn(1, 8'h13, 1, 0, 1, 64'hC4, '0, 0, 0, 0, "R9");
        // R10 snoop write history
        run_txn(0, 8'h04, 1, 0, 0, '0, 64'hA4, 0, 0, 2, "R2");
        run_txn(6, 8'h04, 0, 0, 0, '0, '0, 0, 0, 0, "R10");
        run_txn(1, 8'h04, 1, 0, 0, 64'hB4, '0, 0, 0, 4, "R10");
        run_txn(6, 8'h05, 0, 0, 0, '0, '0, 0, 0, 0, "R10");
        run_txn(1, 8'h05, 1, 0, 0, 64'hB5, '0, 0, 0, 0, "R10");
        run_txn(0, 8'h05, 1, 0, 0, '0, 64'hA5, 0, 0, 2, "R10");
        // R11 snoop read history and forgetting
        run_txn(0, 8'h06, 1, 0, 0, '0, 64'hA6, 0, 0, 2, "R2");
        run_txn(1, 8'h06, 1, 0, 0, 64'hB6, '0, 0, 0, 1, "R1");
        run_txn(5, 8'h06, 0, 0, 0, '0, '0, 0, 0, 0, "R11");
        run_txn(1, 8'h06, 1, 0, 0, 64'hC6, '0, 0, 0, 3, "R11");
        run_txn(2, 8'h06, 0, 0, 0, '0, '0, 0, 0, 4, "R11");
        run_txn(0, 8'h07, 1, 0, 0, '0, 64'hA7, 0, 0, 2, "R2");
        run_txn(6, 8'h07, 0, 0, 0, '0, '0, 0, 0, 0, "R11");
        run_txn(0, 8'h07, 1, 0, 0, '0, '0, 0, 0, 1, "R11");
        run_txn(1, 8'h07, 1, 0, 0, 64'hB7, '0, 0, 0, 1, "R11");
        // R12 address-only operations
        run_txn(2, 8'h07, 0, 0, 0, '0, '0, 0, 1, 5, "R12");
        run_txn(0, 8'h08, 1, 0, 0, '0, 64'hA8, 0, 0, 2, "R2");
        run_txn(3, 8'h08, 0, 0, 0, '0, '0, 0, 0, 0, "R12");
        run_txn(2, 8'h08, 0, 0, 0, '0, '0, 0, 0, 4, "R12");
        run_txn(0, 8'h08, 1, 0, 0, '0, 64'hA9, 0, 0, 2, "R2");
        run_txn(1, 8'h08, 1, 0, 0, 64'hB8, '0, 0, 0, 1, "R1");
        run_txn(3, 8'h08, 0, 0, 0, '0, '0, 0, 1, 5, "R12");
        run_txn(0, 8'h08, 1, 0, 0, '0, '0, 0, 0, 1, "R12");
        run_txn(4, 8'h08, 0, 0, 0, '0, '0, 0, 0, 4, "R12");

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int r = $urandom % 16;
            int k = (r < 5) ? 0 : (r < 10) ? 1 : (r < 11) ? 2 : (r < 12) ? 3 : (r < 13) ? 4 : (r < 14) ? 5 : 6;
            logic [7:0] a = {4'($urandom % 3), 4'($urandom % 4)};
            run_txn(k, a, ($urandom % 4) != 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
                    {$urandom, $urandom}, {$urandom, $urandom}, ($urandom % 8) == 0,
                    ($urandom % 2) == 0, -1, "");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule